// File: doc/BRIEF.md
# Half-Bridge Dead-Time and Cross-Conduction Interlock

This block turns the switching commands for one half-bridge into two gate-on signals, one for the low-side switch and one for the high-side switch. A three-phase bridge uses three copies. The high-side command input is active low. Tying both command inputs to one line therefore gives complementary operation: a high level selects the low-side switch and a low level selects the high-side switch. In that case a single line steers the whole half-bridge, and the block inserts the dead time between the two switches.

When the two commands are driven separately, the block still enforces a minimum dead time. It also discards any request that would turn both switches on. Every switch-on waits a programmable number of clock cycles after the last change of the accepted request, while switch-off follows with a fixed two-cycle latency. A fault supervisor can force either side off. After the force is released, that side stays off until its own command input changes. Control and status pins are plain levels; there is no streaming interface.

Top module: `hb_deadtime_ctl`

## Requirements
- R1: The decoded high-side request is the inverse of `hi_cmd_n`. The decoded low-side request equals `lo_cmd`. With both inputs tied to one line, 1 selects the low side and 0 selects the high side.
- R2: A command change that first appears before clock edge n turns the affected output off after edge n+2.
- R3: An output that is to turn on goes high after edge n+2+L, where L is `dead_cnt`, and a `dead_cnt` of 0 is taken as L=1. The delay counter restarts whenever the accepted request changes.
- R4: The dead time is the same L cycles for a low-to-high switch-over and for a high-to-low switch-over, whatever the preceding on-time.
- R5: If a request to switch over lasts P cycles with P <= L, the outgoing switch still turns off, the incoming switch never turns on, and the outgoing switch returns. For P = L+1 the incoming switch does turn on.
- R6: When the two commands change d < L cycles apart, the outgoing switch turns off per R2, and the incoming switch turns on L cycles after the later change is accepted.
- R7: A decoded request with both sides on is ignored: both outputs keep their states. The next non-conflicting request is accepted normally.
- R8: `gate_lo` and `gate_hi` are never high in the same cycle. An output rises only when the other output was low in the previous cycle.
- R9: A force-off input applied before edge n drives its output low after edge n+1 and holds it low while asserted.
- R10: After a force-off is released, that output stays low until its own command input changes. It then follows its request with the R2/R3 timing.
- R11: During and right after reset both outputs are low, and the accepted request is both-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_cmd | input | 1 | Low-side command, 1 = on |
| hi_cmd_n | input | 1 | High-side command, 0 = on |
| dead_cnt | input | DT_W | Dead time in clock cycles (0 treated as 1) |
| force_lo_off | input | 1 | Force low-side gate off |
| force_hi_off | input | 1 | Force high-side gate off |
| gate_lo | output | 1 | Low-side gate-on |
| gate_hi | output | 1 | High-side gate-on |

## Verification
The hardest case to reach from the ports is two command changes that land a few cycles apart, inside one dead-time window. In one order the first change produces a transient both-on request that must be discarded. The bench drives the second change from inside its per-cycle sampling loop, at a chosen offset, and sweeps that offset across the window in both orders. It also sweeps the pulse width across the boundary between swallowed pulses and pulses that turn the switch on. Lockout realignment is reached by releasing a force-off and toggling only the forced side's own command.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef struct packed {
    logic lo;
    logic hi;
  } side_pair_t;

  localparam int SIDE_LO = 0;
  localparam int SIDE_HI = 1;
  localparam int N_SIDES = 2;
endpackage

// File: rtl/hb_in_sync.sv
module hb_in_sync
  import hb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lo_cmd,
  input  logic       hi_cmd_n,
  input  logic       frc_lo,
  input  logic       frc_hi,
  output side_pair_t req,
  output logic [N_SIDES-1:0] edg,
  output logic [N_SIDES-1:0] frc_q
);
  side_pair_t req_q, prev_q;

  // R1: high-side request is the inverted pin
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      prev_q <= '0;
      frc_q  <= '0;
    end else begin
      req_q.lo <= lo_cmd;
      req_q.hi <= ~hi_cmd_n;
      prev_q   <= req_q;
      frc_q[SIDE_LO] <= frc_lo;
      frc_q[SIDE_HI] <= frc_hi;
    end
  end

  always_comb begin
    req = req_q;
    edg[SIDE_LO] = req_q.lo ^ prev_q.lo;
    edg[SIDE_HI] = req_q.hi ^ prev_q.hi;
  end
endmodule

// File: rtl/hb_interlock.sv
module hb_interlock
  import hb_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  side_pair_t      req,
  input  logic [DT_W-1:0] dead_cnt,
  output side_pair_t      tgt,
  output logic            settled
);
  logic [DT_W-1:0] cnt;
  logic [DT_W-1:0] lim;
  logic            req_ok;
  logic            req_new;

  always_comb begin
    lim     = (dead_cnt == '0) ? DT_W'(1) : dead_cnt;
    req_ok  = !(req.lo && req.hi);
    req_new = req_ok && (req != tgt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt <= '0;
      cnt <= '0;
    end else if (req_new) begin
      tgt <= req;
      cnt <= '0;
    end else if (cnt < lim) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign settled = (cnt >= lim);

  // R7
  conflict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req.lo && req.hi) |=> $stable(tgt));

  // R3
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ok && (req != tgt)) |=> !settled);
endmodule

// File: rtl/hb_gate_stage.sv
module hb_gate_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic frc,
  input  logic in_edge,
  output logic gate
);
  logic blk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk  <= 1'b0;
      gate <= 1'b0;
    end else begin
      blk  <= frc | (blk & ~in_edge);
      gate <= want & ~frc & ~blk;
    end
  end

  // R9
  force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frc |=> !gate);

  // R10
  lockout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && !in_edge) |=> (blk && !gate));
endmodule

// File: rtl/hb_deadtime_ctl.sv
module hb_deadtime_ctl
  import hb_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lo_cmd,
  input  logic            hi_cmd_n,
  input  logic [DT_W-1:0] dead_cnt,
  input  logic            force_lo_off,
  input  logic            force_hi_off,
  output logic            gate_lo,
  output logic            gate_hi
);
  side_pair_t         req;
  side_pair_t         tgt;
  logic               settled;
  logic [N_SIDES-1:0] edg;
  logic [N_SIDES-1:0] frc_q;
  logic [N_SIDES-1:0] want;
  logic [N_SIDES-1:0] gate;

  hb_in_sync u_in (
    .clk     (clk),
    .rst_n   (rst_n),
    .lo_cmd  (lo_cmd),
    .hi_cmd_n(hi_cmd_n),
    .frc_lo  (force_lo_off),
    .frc_hi  (force_hi_off),
    .req     (req),
    .edg     (edg),
    .frc_q   (frc_q)
  );

  hb_interlock #(.DT_W(DT_W)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .dead_cnt(dead_cnt),
    .tgt     (tgt),
    .settled (settled)
  );

  always_comb begin
    want[SIDE_LO] = tgt.lo & settled;
    want[SIDE_HI] = tgt.hi & settled;
  end

  for (genvar g = 0; g < N_SIDES; g++) begin : g_side
    hb_gate_stage u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .want   (want[g]),
      .frc    (frc_q[g]),
      .in_edge(edg[g]),
      .gate   (gate[g])
    );
  end

  assign gate_lo = gate[SIDE_LO];
  assign gate_hi = gate[SIDE_HI];

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_lo && gate_hi));

  // R8
  lo_break_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> !$past(gate_hi));

  // R8
  hi_break_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> !$past(gate_lo));
endmodule

// File: tb/hb_deadtime_ctl_bench.sv
module hb_deadtime_ctl_bench;
  localparam int CLK_NS = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo_cmd = 1'b0;
  logic hi_cmd_n = 1'b1;
  logic frc_lo = 1'b0;
  logic frc_hi = 1'b0;
  logic [DW-1:0] dead = '0;
  logic gate_lo, gate_hi;

  int checks = 0;
  int errors = 0;
  int overlaps = 0;
  bit finished = 0;
  int f_lo, f_hi;
  bit seen_lo, seen_hi;

  always #(CLK_NS/2) clk = ~clk;

  hb_deadtime_ctl #(.DT_W(DW)) u_hb_deadtime_ctl (
    .clk(clk), .rst_n(rst_n), .lo_cmd(lo_cmd), .hi_cmd_n(hi_cmd_n),
    .dead_cnt(dead), .force_lo_off(frc_lo), .force_hi_off(frc_hi),
    .gate_lo(gate_lo), .gate_hi(gate_hi)
  );

  always @(negedge clk) if (rst_n && gate_lo && gate_hi) overlaps++;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // index i = value after the i-th clock edge following the drive
  task automatic run(input int n, input int at2 = 0, input logic lo2 = 1'b0,
                     input logic hin2 = 1'b1);
    logic l0, h0;
    l0 = gate_lo; h0 = gate_hi;
    f_lo = 0; f_hi = 0; seen_lo = 0; seen_hi = 0;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk); @(negedge clk);
      if (gate_lo) seen_lo = 1;
      if (gate_hi) seen_hi = 1;
      if (f_lo == 0 && gate_lo != l0) f_lo = i;
      if (f_hi == 0 && gate_hi != h0) f_hi = i;
      if (i == at2) begin lo_cmd = lo2; hi_cmd_n = hin2; end
    end
  endtask

  task automatic tie(input logic x);
    lo_cmd = x; hi_cmd_n = x;
  endtask

  function automatic int lim_of(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic summary();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL R11 watchdog actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int L;
    repeat (3) @(negedge clk);
    chk("R11", "gate_lo in reset", gate_lo, 0);
    chk("R11", "gate_hi in reset", gate_hi, 0);
    rst_n = 1'b1;
    run(5);
    chk("R11", "lo after reset", seen_lo, 0);
    chk("R11", "hi after reset", seen_hi, 0);

    // R1 R2 R3 R4 tied-input sweep over dead time
    for (int d = 0; d <= 5; d++) begin
      dead = DW'(d); L = lim_of(d);
      tie(1'b0); run(L + 10);
      chk("R1", "tied 0 selects hi", gate_hi, 1);
      chk("R1", "tied 0 lo off", gate_lo, 0);
      tie(1'b1); run(3 + L + 5 + 3 * d);
      chk("R2", "hi off latency", f_hi, 3);
      chk("R3", "lo on latency", f_lo, 3 + L);
      chk("R1", "tied 1 selects lo", gate_lo, 1);
      tie(1'b0); run(3 + L + 4 + d);
      chk("R4", "lo off latency", f_lo, 3);
      chk("R4", "hi on latency", f_hi, 3 + L);
    end

    // R5 short pulses around the dead time
    for (int l5 = 2; l5 <= 4; l5++) begin
      dead = DW'(l5);
      tie(1'b0); run(l5 + 10);
      for (int p = 1; p <= l5 + 1; p++) begin
        tie(1'b1); run(p + l5 + 8, p, 1'b0, 1'b0);
        chk("R5", "incoming on", seen_lo, (p > l5) ? 1 : 0);
        chk("R5", "outgoing off", f_hi, 3);
        chk("R5", "outgoing back", gate_hi, 1);
      end
    end

    // R6 R7 changes closer than the dead time, both orders
    dead = 8'd4; L = 4;
    for (int d = 1; d < L; d++) begin
      lo_cmd = 0; hi_cmd_n = 0; run(L + 10);
      hi_cmd_n = 1; run(d + L + 8, d, 1'b1, 1'b1);
      chk("R6", "hi off first", f_hi, 3);
      chk("R6", "lo on after later", f_lo, d + 3 + L);
      lo_cmd = 0; hi_cmd_n = 0; run(L + 10);
      lo_cmd = 1; run(d + L + 8, d, 1'b1, 1'b1);
      chk("R7", "conflict ignored hi off", f_hi, d + 3);
      chk("R6", "lo on after later rev", f_lo, d + 3 + L);
    end

    // R7 conflicting requests
    dead = 8'd2; L = 2;
    lo_cmd = 1; hi_cmd_n = 1; run(L + 10);
    hi_cmd_n = 0; run(10);
    chk("R7", "lo held", f_lo, 0);
    chk("R7", "hi held", f_hi, 0);
    hi_cmd_n = 1; run(10);
    chk("R7", "lo still on", gate_lo, 1);
    lo_cmd = 0; run(L + 10);
    lo_cmd = 1; hi_cmd_n = 0; run(10);
    chk("R7", "conflict from off lo", seen_lo, 0);
    chk("R7", "conflict from off hi", seen_hi, 0);
    hi_cmd_n = 1; run(L + 6);
    chk("R7", "accept after conflict", f_lo, 3 + L);

    // R9 R10 low-side force and realignment
    frc_lo = 1; run(4);
    chk("R9", "force lo off", f_lo, 2);
    chk("R9", "hi stays off", seen_hi, 0);
    frc_lo = 0; run(10);
    chk("R10", "lo held after release", seen_lo, 0);
    lo_cmd = 0; run(6);
    chk("R10", "lo off after fall", seen_lo, 0);
    lo_cmd = 1; run(L + 6);
    chk("R10", "lo realigned", f_lo, 3 + L);

    // R9 R10 high-side force
    tie(1'b0); run(L + 10);
    frc_hi = 1; run(4);
    chk("R9", "force hi off", f_hi, 2);
    frc_hi = 0; run(10);
    chk("R10", "hi held after release", seen_hi, 0);
    tie(1'b1); run(L + 6);
    chk("R10", "lo on after hi edge", f_lo, 3 + L);
    tie(1'b0); run(L + 6);
    chk("R10", "hi realigned", f_hi, 3 + L);

    chk("R8", "overlap cycles", overlaps, 0);
    summary();
  end
endmodule